// File: doc/BRIEF.md
# Manual Trigger Word Aligner

This block sits behind a deserializer that delivers 10-bit parallel words with no knowledge of where the word boundary lies in the serial stream. The block keeps the previous word and forms a 20-bit window from it and the word now arriving. Ten candidate words can be cut from that window, one per bit offset. When the user raises an alignment request, the block compares every candidate against a programmable pattern. The first cycle in which any candidate matches fixes the shift offset. From then on every output word is cut at that offset.

Alignment is a one-shot action. Once an offset is locked, later data never moves it, even data that carries the pattern at another offset. Only a fresh rising edge on the request clears the lock and starts a new search. A length select chooses between a full 10-bit compare and a partial 7-bit compare that uses only the low bits of the pattern. After lock, a one-cycle detect pulse marks each output word that carries the pattern at the locked offset.

Top module: `walign_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `locked` is 0, `pat_hit` is 0 and `aligned_word` is 0. The held offset is 0, and no search is armed.
- R2: A request rising edge is a cycle in which `align_req` is 1 and was 0 in the previous cycle. Such an edge clears `locked` from the next cycle on and arms a search. The first compare takes place in the cycle after that edge. Holding `align_req` high does not re-arm a search.
- R3: While a search is armed, the first cycle in which some offset k matches sets `locked` from the next cycle on and stores k. In that same next cycle `aligned_word` already equals bits k+9..k of the window {current raw word, previous raw word}. The current word is the high half, and bit 0 of the previous word is window bit 0.
- R4: Once `locked` is 1, neither the data nor the pattern changes the stored offset or clears `locked`, until the next request rising edge.
- R5: When several offsets match in the same cycle of a search, the lowest offset is stored.
- R6: With `pat_short` = 1, a candidate matches when its bits 6..0 equal `pattern` bits 6..0, and bits 9..7 are ignored. With `pat_short` = 0, all 10 bits must be equal.
- R7: `pat_hit` is 1 for one cycle in the cycle in which lock is taken. It is also 1 in every cycle whose `aligned_word` comes from a window that matched at the locked offset, while locked and without a request rising edge in that window's cycle. Otherwise it is 0.
- R8: `aligned_word` is registered. At offset 0 it equals the raw word presented two cycles earlier.
- R9: Between a request rising edge and the lock, `locked` and `pat_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_word | input | 10 | Unaligned word from the deserializer |
| align_req | input | 1 | Alignment request; a rising edge starts one search |
| pattern | input | 10 | Alignment pattern to search for |
| pat_short | input | 1 | 1: compare low 7 bits only; 0: compare all 10 bits |
| aligned_word | output | 10 | Word cut at the locked offset, registered |
| pat_hit | output | 1 | Pattern seen at the locked offset, or lock just taken |
| locked | output | 1 | An offset has been found since the last request edge |

## Verification
A single pattern is placed at one interior offset on an all-zero background to show that the offset found is the one the pattern was placed at. A periodic pattern that matches at offsets 2, 4, 6 and 8 together shows whether the lowest offset wins. The word that follows is then checked, because offset 2 and offset 4 cut it differently. One window fits the 7-bit compare but differs in the upper three bits, so it is tried in both length modes to separate the partial compare from the full compare. A lock at offset 0 followed by distinct words measures the latency. A long random stream with request toggles, injected patterns and mode changes then exercises lock hold, re-arming and the detect pulse against a reference model.

// File: rtl/walign_pkg.sv
`timescale 1ns/1ps
package walign_pkg;

    localparam int WORD_W  = 10;
    localparam int SHORT_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_e;

    // compare mask: all bits, or only the low short_w bits
    function automatic logic [WORD_W-1:0] cmp_mask(input logic short_mode,
                                                   input int   short_w);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (!short_mode) || (i < short_w);
        end
        return m;
    endfunction

endpackage

// File: rtl/walign_window.sv
`timescale 1ns/1ps
module walign_window #(
    parameter int WORD_W = walign_pkg::WORD_W,
    localparam int WIN_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] raw_word,
    output logic [WIN_W-1:0]  window
);

    logic [WORD_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= raw_word;
        end
    end

    assign window = {raw_word, prev_q};

endmodule

// File: rtl/walign_match.sv
`timescale 1ns/1ps
module walign_match #(
    parameter int WORD_W  = walign_pkg::WORD_W,
    parameter int SHORT_W = walign_pkg::SHORT_W,
    localparam int WIN_W  = 2 * WORD_W
) (
    input  logic [WIN_W-1:0]  window,
    input  logic [WORD_W-1:0] pattern,
    input  logic              pat_short,
    output logic [WORD_W-1:0] match_vec
);

    logic [WORD_W-1:0] mask;

    assign mask = walign_pkg::cmp_mask(pat_short, SHORT_W);

    for (genvar k = 0; k < WORD_W; k++) begin : g_cand
        logic [WORD_W-1:0] cand;
        assign cand         = window[k +: WORD_W];
        assign match_vec[k] = ((cand ^ pattern) & mask) == '0;
    end

endmodule

// File: rtl/walign_prio.sv
`timescale 1ns/1ps
module walign_prio #(
    parameter int WORD_W = walign_pkg::WORD_W,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] match_vec,
    output logic              any_match,
    output logic [OFF_W-1:0]  first_idx,
    output logic [WORD_W-1:0] grant
);

    always_comb begin
        any_match = 1'b0;
        first_idx = '0;
        grant     = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (match_vec[k]) begin
                any_match = 1'b1;
                first_idx = OFF_W'(k);
                grant     = '0;
                grant[k]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/walign_ctrl.sv
`timescale 1ns/1ps
module walign_ctrl #(
    parameter int WORD_W = walign_pkg::WORD_W,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              align_req,
    input  logic              any_match,
    input  logic [OFF_W-1:0]  first_idx,
    input  logic [WORD_W-1:0] match_vec,
    output logic [OFF_W-1:0]  off_sel,
    output logic              locked,
    output logic              pat_hit
);
    import walign_pkg::*;

    align_state_e     state_q, state_d;
    logic             req_q;
    logic [OFF_W-1:0] off_q;
    logic             hit_q;
    logic             req_rise;
    logic             lock_now;
    logic             at_off;

    assign req_rise = align_req & ~req_q;
    assign lock_now = (state_q == ST_SEARCH) & any_match & ~req_rise;
    assign off_sel  = lock_now ? first_idx : off_q;

    always_comb begin
        at_off = 1'b0;
        for (int k = 0; k < WORD_W; k++) begin
            if (off_q == OFF_W'(k)) begin
                at_off = match_vec[k];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (req_rise) begin
            state_d = ST_SEARCH;
        end else if (lock_now) begin
            state_d = ST_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
            off_q   <= '0;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= align_req;
            off_q   <= off_sel;
            hit_q   <= lock_now | ((state_q == ST_LOCKED) & ~req_rise & at_off);
        end
    end

    assign locked  = (state_q == ST_LOCKED);
    assign pat_hit = hit_q;

endmodule

// File: rtl/walign_shift.sv
`timescale 1ns/1ps
module walign_shift #(
    parameter int WORD_W = walign_pkg::WORD_W,
    localparam int WIN_W = 2 * WORD_W,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIN_W-1:0]  window,
    input  logic [OFF_W-1:0]  off_sel,
    output logic [WORD_W-1:0] aligned_word
);

    logic [WORD_W-1:0] cand [WORD_W];
    logic [WORD_W-1:0] picked;

    for (genvar k = 0; k < WORD_W; k++) begin : g_tap
        assign cand[k] = window[k +: WORD_W];
    end

    always_comb begin
        picked = cand[0];
        for (int k = 1; k < WORD_W; k++) begin
            if (off_sel == OFF_W'(k)) begin
                picked = cand[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aligned_word <= '0;
        end else begin
            aligned_word <= picked;
        end
    end

endmodule

// File: rtl/walign_top.sv
`timescale 1ns/1ps
module walign_top #(
    parameter int WORD_W  = walign_pkg::WORD_W,
    parameter int SHORT_W = walign_pkg::SHORT_W,
    localparam int WIN_W  = 2 * WORD_W,
    localparam int OFF_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] raw_word,
    input  logic              align_req,
    input  logic [WORD_W-1:0] pattern,
    input  logic              pat_short,
    output logic [WORD_W-1:0] aligned_word,
    output logic              pat_hit,
    output logic              locked
);

    logic [WIN_W-1:0]  window;
    logic [WORD_W-1:0] match_vec;
    logic [WORD_W-1:0] grant_vec;
    logic              any_match;
    logic [OFF_W-1:0]  first_idx;
    logic [OFF_W-1:0]  off_sel;

    walign_window #(.WORD_W(WORD_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .raw_word (raw_word),
        .window   (window)
    );

    walign_match #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_match (
        .window    (window),
        .pattern   (pattern),
        .pat_short (pat_short),
        .match_vec (match_vec)
    );

    walign_prio #(.WORD_W(WORD_W)) u_prio (
        .match_vec (match_vec),
        .any_match (any_match),
        .first_idx (first_idx),
        .grant     (grant_vec)
    );

    walign_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .align_req (align_req),
        .any_match (any_match),
        .first_idx (first_idx),
        .match_vec (match_vec),
        .off_sel   (off_sel),
        .locked    (locked),
        .pat_hit   (pat_hit)
    );

    walign_shift #(.WORD_W(WORD_W)) u_shift (
        .clk          (clk),
        .rst          (rst),
        .window       (window),
        .off_sel      (off_sel),
        .aligned_word (aligned_word)
    );

endmodule

// File: rtl/walign_checker.sv
`timescale 1ns/1ps
module walign_checker #(
    parameter int WORD_W = walign_pkg::WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              align_req,
    input logic              locked,
    input logic              pat_hit,
    input logic [WORD_W-1:0] aligned_word,
    input logic [WORD_W-1:0] match_vec,
    input logic [WORD_W-1:0] grant_vec
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: outputs cleared right after a reset edge
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (!locked && !pat_hit && aligned_word == '0);
        end
    end

    // R2: request edge drops the lock
    a_r2_rise_unlocks: assert property (@(posedge clk) disable iff (rst)
        $rose(align_req) |=> !locked);

    // R4: lock persists without a new request edge
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (locked && !$rose(align_req)) |=> locked);

    // R3: taking the lock always comes with the detect pulse
    a_r3_lock_with_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> pat_hit);

    // R9: no detect pulse while unlocked
    a_r9_hit_needs_lock: assert property (@(posedge clk) disable iff (rst)
        pat_hit |-> locked);

    // R5: priority picks exactly one offset when any match
    a_r5_single_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec) && ((match_vec != '0) == (grant_vec != '0)));

endmodule

bind walign_top walign_checker #(.WORD_W(WORD_W)) u_walign_checker (
    .clk          (clk),
    .rst          (rst),
    .align_req    (align_req),
    .locked       (locked),
    .pat_hit      (pat_hit),
    .aligned_word (aligned_word),
    .match_vec    (match_vec),
    .grant_vec    (grant_vec)
);

// File: tb/walign_top_bench.sv
`timescale 1ns/1ps
module walign_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] raw_word = '0;
    logic       align_req = 1'b0;
    logic [9:0] pattern = '0;
    logic       pat_short = 1'b0;
    logic [9:0] aligned_word;
    logic       pat_hit;
    logic       locked;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string tag = "R1";

    // reference model state
    logic [9:0] m_prev = '0;
    logic       m_req  = 1'b0;
    int         m_state = 0;   // 0 idle, 1 searching, 2 locked
    int         m_off   = 0;
    logic [9:0] e_al   = '0;
    logic       e_hit  = 1'b0;
    logic       e_lock = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    walign_top u_walign_top (
        .clk          (clk),
        .rst          (rst),
        .raw_word     (raw_word),
        .align_req    (align_req),
        .pattern      (pattern),
        .pat_short    (pat_short),
        .aligned_word (aligned_word),
        .pat_hit      (pat_hit),
        .locked       (locked)
    );

    task automatic chk(input string t, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, got, exp);
        end
    endtask

    task automatic model_next();
        logic [19:0] win;
        logic [9:0]  mask;
        logic [9:0]  mt;
        logic        any, rise, lock_now;
        int          idx, sel;
        win  = {raw_word, m_prev};
        mask = pat_short ? 10'h07F : 10'h3FF;
        any = 0; idx = 0;
        for (int k = 9; k >= 0; k--) begin
            mt[k] = (((win[k +: 10]) ^ pattern) & mask) == 10'h000;
            if (mt[k]) begin any = 1; idx = k; end
        end
        rise     = align_req && !m_req;
        lock_now = (m_state == 1) && any && !rise;
        sel      = lock_now ? idx : m_off;
        e_al     = win[sel +: 10];
        e_hit    = lock_now || (m_state == 2 && !rise && mt[m_off]);
        if (rise) m_state = 1;
        else if (lock_now) m_state = 2;
        m_off  = sel;
        m_req  = align_req;
        m_prev = raw_word;
        e_lock = (m_state == 2);
    endtask

    task automatic compare();
        chk(tag, "aligned_word", int'(aligned_word), int'(e_al));
        chk(tag, "pat_hit", int'(pat_hit), int'(e_hit));
        chk(tag, "locked", int'(locked), int'(e_lock));
    endtask

    // called at a negedge: drive, advance model, sample at next negedge
    task automatic step(input logic [9:0] raw, input logic req);
        raw_word  = raw;
        align_req = req;
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    // place a 10-bit slice value at offset k across two words
    task automatic embed(input int k, input logic [9:0] val, input logic req);
        logic [19:0] w;
        w = 20'(val) << k;
        step(w[9:0], req);
        step(w[19:10], req);
    endtask

    task automatic rearm();
        step(10'h000, 1'b0);
        step(10'h000, 1'b1);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        chk("R1", "locked after reset", int'(locked), 0);
        chk("R1", "pat_hit after reset", int'(pat_hit), 0);
        chk("R1", "aligned after reset", int'(aligned_word), 0);

        // R2: data alone never locks
        tag = "R2";
        pattern = 10'b0011111010;
        for (int i = 0; i < 20; i++) step(10'($urandom), 1'b0);
        for (int i = 0; i < 4; i++) step(10'h000, 1'b0);
        embed(3, pattern, 1'b0);
        chk("R2", "no lock without request", int'(locked), 0);

        // R3 / R9: request, then pattern at offset 3
        tag = "R9";
        rearm();
        step(10'h000, 1'b1);
        chk("R9", "unlocked while searching", int'(locked), 0);
        tag = "R3";
        embed(3, pattern, 1'b1);
        chk("R3", "locked after match", int'(locked), 1);
        chk("R3", "aligned shows pattern", int'(aligned_word), int'(pattern));
        chk("R7", "hit at lock", int'(pat_hit), 1);
        step(10'h000, 1'b1);
        chk("R7", "hit is one cycle", int'(pat_hit), 0);

        // R4: pattern at another offset, request held high
        tag = "R4";
        embed(6, pattern, 1'b1);
        step(10'h000, 1'b1);
        for (int i = 0; i < 30; i++) step(10'($urandom), 1'b1);
        chk("R4", "lock held", int'(locked), 1);
        tag = "R7";
        for (int i = 0; i < 3; i++) step(10'h000, 1'b1);
        embed(3, pattern, 1'b1);
        chk("R7", "hit at locked offset", int'(pat_hit), 1);
        chk("R7", "aligned at locked offset", int'(aligned_word), int'(pattern));

        // R2: new edge clears lock
        tag = "R2";
        step(10'h000, 1'b0);
        step(10'h000, 1'b1);
        chk("R2", "edge clears lock", int'(locked), 0);

        // R5: matches at 2,4,6,8 together; offset 2 must win
        tag = "R5";
        pattern = 10'b0101010101;
        step(10'h000, 1'b1);
        step(10'h154, 1'b1);
        step(10'h155, 1'b1);
        chk("R5", "locked on multi match", int'(locked), 1);
        step(10'h000, 1'b1);
        chk("R5", "lowest offset cut", int'(aligned_word), 10'h055);

        // R6: partial compare
        tag = "R6";
        pattern = 10'b1110000011;
        pat_short = 1'b0;
        rearm();
        step(10'h000, 1'b1);
        embed(5, 10'b0000000011, 1'b1);
        step(10'h000, 1'b1);
        chk("R6", "full compare rejects", int'(locked), 0);
        pat_short = 1'b1;
        rearm();
        step(10'h000, 1'b1);
        embed(5, 10'b0000000011, 1'b1);
        chk("R6", "short compare locks", int'(locked), 1);
        chk("R6", "short hit", int'(pat_hit), 1);
        pat_short = 1'b0;

        // R8: offset 0 latency
        tag = "R8";
        pattern = 10'b0011111010;
        rearm();
        step(10'h000, 1'b1);
        embed(0, pattern, 1'b1);
        chk("R8", "locked at offset 0", int'(locked), 1);
        step(10'h123, 1'b1);
        step(10'h2AB, 1'b1);
        chk("R8", "two cycle latency", int'(aligned_word), 10'h123);
        step(10'h0F0, 1'b1);
        chk("R8", "two cycle latency b", int'(aligned_word), 10'h2AB);

        // random mix
        tag = "R7";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 4) pat_short = ~pat_short;
            if (r < 10) embed(int'($urandom % 10), pattern, align_req ^ (r < 5));
            else step(10'($urandom), (r > 93) ? ~align_req : align_req);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule